// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns one decoded memory operand into an effective address. Each accepted request supplies an addressing mode, the base and index register values, the base register number, an index scale, a displacement (a short field from the instruction or a value assembled from extension words), an access size and a bit that scales the short displacement. One cycle later the block pulses `done` with the address, a misalignment flag and, for the auto-modify modes, the updated base value with a writeback strobe.

Array mode needs one memory read. The block adds the displacement to the base to form a table slot address and issues a one-cycle `tbl_req`. It stays busy until `tbl_valid` returns the array start address. It then adds the scaled index to that start address and pulses `done` in the next cycle. Short displacements come in two widths, chosen by which group the base register number falls in. A number outside both groups, an unused displacement selector or an unused mode code produces a fault. A faulted request completes with no address and no side effect.

Top module: `mem_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `done`, `fault`, `misalign`, `base_wb`, `tbl_req` and `busy` are low.
- R2: Mode 1 (indirect) returns `addr` equal to the base value. `done` is high in the cycle after the request is accepted, and `base_wb` stays low.
- R3: Mode 2 (post-increment) returns the old base as `addr`. It pulses `base_wb` with `done`, and `base_new` is the base plus the access size in bytes. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R4: Mode 3 (pre-decrement) subtracts the access size from the base. It returns that result both as `addr` and as `base_new`, with `base_wb` high.
- R5: Mode 4 (indexed) returns base + (index << scale) + displacement. The displacement selector picks the displacement: 0 takes the short field, 1 takes the low 32 bits of `ext_disp` sign-extended from bit 31, and 2 takes all of `ext_disp`.
- R6: With a short displacement, base numbers 1 to 7 use all 16 bits of `short_disp`, sign-extended from bit 15. Base numbers 8 to 14 use its low 12 bits, sign-extended from bit 11.
- R7: When `disp_scale` is set, the sign-extended short displacement is shifted left by the size code. The bit does not affect extension-word displacements.
- R8: The request faults in three cases: a short displacement used with base number 0 or 15 in mode 4 or 5, displacement selector 3 in mode 4 or 5, or mode 6 or 7. A faulted request gives `done` with `fault` high and `addr` zero. It raises no `base_wb`, no `misalign` and no `tbl_req`.
- R9: Mode 5 (array) pulses `tbl_req` for one cycle, with `tbl_addr` set to the base plus the displacement, and raises `busy`. The first `tbl_valid` clears `busy`. `done` follows in the next cycle, with `addr` set to `tbl_data` + (index << scale).
- R10: A request presented while `busy` is high is ignored: it produces no `done` and no `tbl_req`. A `tbl_valid` arriving while `busy` is low is also ignored.
- R11: `misalign` is high with `done` when the produced address is not a multiple of the access size. The address is still returned.
- R12: Mode 0 (register direct) completes with `done` high, `addr` zero and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| mode | input | 3 | Addressing mode code |
| base_num | input | 4 | Base register number |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| scale | input | 2 | Index left-shift amount |
| disp_sel | input | 2 | Displacement source selector |
| short_disp | input | 16 | Short displacement field |
| ext_disp | input | AW | Extension-word displacement value |
| size | input | 2 | Access size code |
| disp_scale | input | 1 | Scale short displacement by size |
| tbl_req | output | 1 | Pointer table read request |
| tbl_addr | output | AW | Pointer table slot address |
| tbl_valid | input | 1 | Table read reply strobe |
| tbl_data | input | AW | Array start address from the table |
| busy | output | 1 | Waiting for a table reply |
| done | output | 1 | Result valid pulse |
| addr | output | AW | Effective address |
| base_wb | output | 1 | Base writeback strobe |
| base_new | output | AW | Updated base value |
| misalign | output | 1 | Address not a multiple of the size |
| fault | output | 1 | Illegal mode or displacement |

## Verification
The reference model tracks its own busy state. A busy flag that sticks or clears early shows up at the ports within one cycle, as a missing or extra `done`, or as a stray `tbl_req` when a request arrives during the wait. If the held index or size is corrupted, nothing shows until the table reply comes back: the array-mode `addr` or `misalign` is then wrong in the `done` cycle. Displacement width or sign errors show in the same cycle as the indexed result. The tests use negative short fields in both groups and high bits that must be discarded.

// File: rtl/mem_addr_gen.sv
module mem_addr_gen #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    mode,
  input  logic [3:0]    base_num,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale,
  input  logic [1:0]    disp_sel,
  input  logic [15:0]   short_disp,
  input  logic [AW-1:0] ext_disp,
  input  logic [1:0]    size,
  input  logic          disp_scale,
  output logic          tbl_req,
  output logic [AW-1:0] tbl_addr,
  input  logic          tbl_valid,
  input  logic [AW-1:0] tbl_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr,
  output logic          base_wb,
  output logic [AW-1:0] base_new,
  output logic          misalign,
  output logic          fault
);
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_POST = 3'd2,
                         M_PRE = 3'd3, M_IDX = 3'd4, M_ARR = 3'd5;

  logic          grp16, grp12, uses_disp, bad, accept, reply;
  logic [AW-1:0] size_b, sdisp, disp, sidx, idx_hold, pre_val, idx_sum, arr_sum;
  logic [1:0]    size_hold;

  assign grp16     = base_num >= 4'd1 && base_num <= 4'd7;
  assign grp12     = base_num >= 4'd8 && base_num <= 4'd14;
  assign uses_disp = mode == M_IDX || mode == M_ARR;
  assign bad       = mode > M_ARR ||
                     (uses_disp && (disp_sel == 2'd3 || (disp_sel == 2'd0 && !grp16 && !grp12)));
  assign accept    = req_valid && !busy;
  assign reply     = busy && tbl_valid;

  assign size_b = AW'(1) << size;
  assign sdisp  = (grp16 ? {{(AW-16){short_disp[15]}}, short_disp}
                         : {{(AW-12){short_disp[11]}}, short_disp[11:0]}) << (disp_scale ? size : 2'd0);
  always_comb begin
    case (disp_sel)
      2'd0:    disp = sdisp;
      2'd1:    disp = {{(AW-32){ext_disp[31]}}, ext_disp[31:0]};
      2'd2:    disp = ext_disp;
      default: disp = '0;
    endcase
  end
  assign sidx    = index_val << scale;
  assign pre_val = base_val - size_b;
  assign idx_sum = base_val + sidx + disp;
  assign arr_sum = tbl_data + idx_hold;

  function automatic logic odd(input logic [AW-1:0] a, input logic [1:0] sz);
    return |(a & ((AW'(1) << sz) - AW'(1)));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; tbl_req <= 1'b0; base_wb <= 1'b0;
      misalign <= 1'b0; fault <= 1'b0;
      addr <= '0; base_new <= '0; tbl_addr <= '0; idx_hold <= '0; size_hold <= '0;
    end else begin
      done <= 1'b0; tbl_req <= 1'b0; base_wb <= 1'b0; misalign <= 1'b0; fault <= 1'b0;
      if (accept) begin
        if (bad) begin
          done <= 1'b1; fault <= 1'b1; addr <= '0;
        end else begin
          case (mode)
            M_IND:  begin done <= 1'b1; addr <= base_val; misalign <= odd(base_val, size); end
            M_POST: begin
              done <= 1'b1; addr <= base_val; misalign <= odd(base_val, size);
              base_wb <= 1'b1; base_new <= base_val + size_b;
            end
            M_PRE:  begin
              done <= 1'b1; addr <= pre_val; misalign <= odd(pre_val, size);
              base_wb <= 1'b1; base_new <= pre_val;
            end
            M_IDX:  begin done <= 1'b1; addr <= idx_sum; misalign <= odd(idx_sum, size); end
            M_ARR:  begin
              tbl_req <= 1'b1; busy <= 1'b1; tbl_addr <= base_val + disp;
              idx_hold <= sidx; size_hold <= size;
            end
            default: begin done <= 1'b1; addr <= '0; end
          endcase
        end
      end else if (reply) begin
        busy <= 1'b0; done <= 1'b1; addr <= arr_sum; misalign <= odd(arr_sum, size_hold);
      end
    end
  end

  AST_TBL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tbl_req |=> !tbl_req); // R9
  AST_TBL_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tbl_req |-> busy); // R9
  AST_REPLY_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done && !fault); // R9
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) fault |-> done && !base_wb && !misalign && !tbl_req); // R8
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) base_wb |-> done); // R3
  AST_NO_DONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> !done); // R10
endmodule

// File: tb/test_mem_addr_gen.sv
module test_mem_addr_gen;
  localparam int AW = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, disp_scale = 1'b0, tbl_valid = 1'b0;
  logic [2:0] mode = '0;
  logic [3:0] base_num = '0;
  logic [1:0] scale = '0, disp_sel = '0, size = '0;
  logic [15:0] short_disp = '0;
  logic [AW-1:0] base_val = '0, index_val = '0, ext_disp = '0, tbl_data = '0;
  logic tbl_req, busy, done, base_wb, misalign, fault;
  logic [AW-1:0] tbl_addr, addr, base_new;

  mem_addr_gen #(.AW(AW)) i_mem_addr_gen (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  string tag = "R1";

  bit e_done, e_fault, e_mis, e_wb, e_req, m_busy;
  longint e_addr, e_new, e_taddr, m_idx;
  int m_size;

  function automatic longint m_disp(input int sel, input int bn, input logic [15:0] sd,
                                    input longint ext, input bit sc, input int sz);
    longint v;
    if (sel == 1) return longint'($signed(ext[31:0]));
    if (sel == 2) return ext;
    if (bn <= 7) v = longint'($signed(sd));
    else v = longint'($signed(sd[11:0]));
    if (sc) v = v * (longint'(1) << sz);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_done = 0; e_fault = 0; e_mis = 0; e_wb = 0; e_req = 0; m_busy = 0;
    end else begin
      int bytes;
      bit illegal;
      e_done = 0; e_fault = 0; e_mis = 0; e_wb = 0; e_req = 0;
      bytes = 1 << size;
      illegal = mode > 5 || ((mode == 4 || mode == 5) &&
                (disp_sel == 3 || (disp_sel == 0 && (base_num == 0 || base_num == 15))));
      if (req_valid && !m_busy) begin
        longint d, ix;
        d = m_disp(disp_sel, base_num, short_disp, ext_disp, disp_scale, size);
        ix = index_val * (longint'(1) << scale);
        if (illegal) begin e_done = 1; e_fault = 1; e_addr = 0; end
        else if (mode == 0) begin e_done = 1; e_addr = 0; end
        else if (mode == 5) begin
          e_req = 1; m_busy = 1; e_taddr = base_val + d; m_idx = ix; m_size = bytes;
        end else begin
          e_done = 1;
          if (mode == 1 || mode == 2) e_addr = base_val;
          if (mode == 3) e_addr = base_val - bytes;
          if (mode == 4) e_addr = base_val + ix + d;
          if (mode == 2) begin e_wb = 1; e_new = base_val + bytes; end
          if (mode == 3) begin e_wb = 1; e_new = e_addr; end
          e_mis = (e_addr % bytes) != 0;
        end
      end else if (m_busy && tbl_valid) begin
        m_busy = 0; e_done = 1; e_addr = tbl_data + m_idx; e_mis = (e_addr % m_size) != 0;
      end
    end
  end

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, "done", done, e_done);
    chk("R8", "fault", fault, e_fault);
    chk("R11", "misalign", misalign, e_mis);
    chk(tag, "base_wb", base_wb, e_wb);
    chk(tag, "tbl_req", tbl_req, e_req);
    chk("R10", "busy", busy, m_busy);
    if (e_done) chk(tag, "addr", addr, e_addr);
    if (e_wb) chk(tag, "base_new", base_new, e_new);
    if (e_req) chk("R9", "tbl_addr", tbl_addr, e_taddr);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(input string r, input int m, input int bn, input longint b, input longint ix,
                     input int sc, input int sel, input logic [15:0] sd, input longint ex,
                     input int sz, input bit ds);
    @(negedge clk);
    tag = r; mode = 3'(m); base_num = 4'(bn); base_val = b; index_val = ix; scale = 2'(sc);
    disp_sel = 2'(sel); short_disp = sd; ext_disp = ex; size = 2'(sz); disp_scale = ds;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reply(input longint d);
    @(negedge clk);
    tbl_valid = 1'b1; tbl_data = d;
    @(negedge clk);
    tbl_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {done, fault, misalign, base_wb, tbl_req, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset outputs", {done, fault, misalign, base_wb, tbl_req, busy}, 0);
    req("R12", 0, 1, 64'h55, 0, 0, 0, 0, 0, 3, 0);
    req("R2", 1, 1, 64'h1000, 0, 0, 0, 0, 0, 2, 0);
    req("R11", 1, 1, 64'h1001, 0, 0, 0, 0, 0, 1, 0);
    req("R3", 2, 2, 64'h2000, 0, 0, 0, 0, 0, 3, 0);
    req("R4", 3, 2, 64'h2000, 0, 0, 0, 0, 0, 1, 0);
    req("R5", 4, 3, 64'h3000, 5, 3, 0, 16'hFFF8, 0, 3, 0);
    req("R5", 4, 3, 64'h10000_0000, 1, 0, 1, 0, 64'hFFFF_0000_8000_0000, 0, 0);
    req("R5", 4, 3, 64'h100, 2, 1, 2, 0, 64'h1234_5678_9ABC_DEF0, 0, 0);
    req("R6", 4, 9, 64'h4000, 0, 0, 0, 16'hF800, 0, 0, 0);
    req("R6", 4, 14, 64'h4000, 0, 0, 0, 16'hA7FF, 0, 0, 0);
    req("R6", 4, 7, 64'h4000, 0, 0, 0, 16'h8000, 0, 0, 0);
    req("R7", 4, 1, 64'h5000, 0, 0, 0, 16'h0003, 0, 2, 1);
    req("R7", 4, 8, 64'h5000, 0, 0, 0, 16'h0FFF, 0, 3, 1);
    req("R7", 4, 1, 64'h5000, 0, 0, 1, 0, 64'h3, 2, 1);
    req("R8", 4, 0, 64'h6000, 1, 0, 0, 16'h4, 0, 0, 0);
    req("R8", 5, 15, 64'h6000, 1, 0, 0, 16'h4, 0, 0, 0);
    req("R8", 7, 1, 64'h6000, 0, 0, 0, 0, 0, 0, 0);
    req("R8", 4, 2, 64'h6000, 0, 0, 3, 0, 0, 0, 0);
    req("R9", 5, 2, 64'h4000, 3, 2, 0, 16'h0010, 0, 2, 0);
    @(negedge clk);
    req("R10", 1, 1, 64'h7777, 0, 0, 0, 0, 0, 0, 0);
    tag = "R9";
    reply(64'h9000);
    @(negedge clk);
    reply(64'hDEAD);
    tag = "R10";
    @(negedge clk);
    req("R11", 5, 9, 64'h8000, 1, 0, 1, 0, 64'h8, 3, 0);
    tag = "R9";
    reply(64'hA002);
    req("R3", 2, 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
    req("R4", 3, 5, 64'h0, 0, 0, 0, 0, 0, 2, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule